// File: doc/BRIEF.md
# Change-Tracking Video Memory Bank

This block holds the storage that a tile video controller renders from: a pattern RAM of byte-wide tile data, a 128-byte colour RAM, a 128-byte scroll RAM and a file of 32 eight-bit control registers. Every write is compared against the byte already stored. Only a write that really alters a location updates it and marks the change. A renderer can then skip the tiles, palette entries and settings that have not moved since its last pass.

Changes are recorded at a granularity suited to each store. The pattern RAM has one mark per 256-byte page. The colour RAM and the register file have one mark per byte. The scroll RAM only raises a store-level flag. A four-bit summary tells which stores changed at all. A one-cycle clear strobe starts a new tracking interval. Out of reset every mark and flag is set, so the first frame redraws everything.

The pattern RAM depth is the parameter `PAT_AW`: 16 gives the full 64 KiB and 256 page marks. The default of 12 (4 KiB, 16 page marks) keeps elaboration small. Byte reads are synchronous on four independent read ports.

Top module: `tile_mem_tracker`

## Requirements
- R1: The byte write port selects its store with `wr_tgt`: 0 is pattern RAM, 1 colour RAM, 2 scroll RAM and 3 no store. A code-3 write changes no memory and no mark. Pattern writes use `wr_addr[PAT_AW-1:0]`. Colour and scroll writes use only `wr_addr[6:0]`, so higher address bits alias.
- R2: A write, byte or register, whose data equals the stored byte leaves the memory, every mark and every summary flag unchanged.
- R3: A pattern write that changes a byte sets `pat_dirty[wr_addr[PAT_AW-1:8]]`, which is one mark per 256-byte page.
- R4: A colour write that changes a byte sets `col_dirty[wr_addr[6:0]]`, which is one mark per byte.
- R5: A register write that changes a register sets `reg_dirty[reg_addr]`, which is one mark per register.
- R6: On any change the summary `chg_summary` sets bit 0 for pattern, bit 1 for colour, bit 2 for scroll and bit 3 for registers. The scroll RAM has no per-location marks.
- R7: After reset every mark and summary bit is 1, and every memory byte and register reads 0.
- R8: A cycle with `dirty_clr` high zeroes every mark and summary bit. A changing write in that same cycle still sets its own marks and summary bit.
- R9: A write is stored at the clock edge where it is presented. A read returns the addressed byte one cycle after its address is presented. A read in the same cycle as a write to that location returns the old byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_tgt | input | 2 | Store select (0 pattern, 1 colour, 2 scroll, 3 none) |
| wr_addr | input | 16 | Byte write address |
| wr_data | input | 8 | Byte write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_data | input | 8 | Register write data |
| dirty_clr | input | 1 | Clear all marks and summary bits |
| pat_raddr | input | PAT_AW | Pattern RAM read address |
| col_raddr | input | 7 | Colour RAM read address |
| scr_raddr | input | 7 | Scroll RAM read address |
| reg_raddr | input | 5 | Register read index |
| pat_rdata | output | 8 | Pattern RAM read data |
| col_rdata | output | 8 | Colour RAM read data |
| scr_rdata | output | 8 | Scroll RAM read data |
| reg_rdata | output | 8 | Register read data |
| pat_dirty | output | 2**(PAT_AW-8) | Pattern page marks |
| col_dirty | output | 128 | Colour byte marks |
| reg_dirty | output | 32 | Register marks |
| chg_summary | output | 4 | Per-store change flags |

## Verification
Each write in the vector table comes after a clear. Every store gets one write that changes its contents and the identical write repeated, which separates real change detection from plain write detection. An aliased colour address and the highest page and byte indices show whether the right address bits reach the marks. A code-3 write shows that an unselected write is ignored. Directed cases cover the reset contents, a clear with a write in the same cycle, register writes, and a read in the same cycle as a write, which tells read-before-write from write-through.

// File: rtl/tile_mem_pkg.sv
package tile_mem_pkg;

    localparam int BYTE_W   = 8;
    localparam int SMALL_AW = 7;
    localparam int REG_AW   = 5;
    localparam int HOST_AW  = 16;
    localparam int PAGE_LSB = 8;
    localparam int N_STORES = 4;

    typedef enum logic [1:0] {
        TGT_PAT  = 2'd0,
        TGT_COL  = 2'd1,
        TGT_SCR  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    // summary bit positions
    localparam int SUM_PAT = 0;
    localparam int SUM_COL = 1;
    localparam int SUM_SCR = 2;
    localparam int SUM_REG = 3;

    typedef struct packed {
        logic                en;
        tgt_e                tgt;
        logic [HOST_AW-1:0]  addr;
        logic [BYTE_W-1:0]   data;
    } byte_wr_t;

    typedef struct packed {
        logic                en;
        logic [REG_AW-1:0]   idx;
        logic [BYTE_W-1:0]   data;
    } reg_wr_t;

    function automatic logic hits(input byte_wr_t w, input tgt_e t);
        return w.en && (w.tgt == t);
    endfunction

endpackage

// File: rtl/tracked_ram.sv
module tracked_ram
    import tile_mem_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          changed
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // compare against current contents before the edge commits
    assign changed = we && (mem[waddr] != wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
            if (changed) begin
                mem[waddr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dirty_map.sv
module dirty_map #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [BITS-1:0] set_mask,
    output logic [BITS-1:0] map
);
    // a bit being set wins over the clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            map <= '1;
        end else if (clr) begin
            map <= set_mask;
        end else begin
            map <= map | set_mask;
        end
    end

endmodule

// File: rtl/tile_mem_tracker.sv
module tile_mem_tracker
    import tile_mem_pkg::*;
#(
    parameter int PAT_AW = 12,
    localparam int PAGES = 1 << (PAT_AW - PAGE_LSB),
    localparam int SMALL_DEPTH = 1 << SMALL_AW,
    localparam int REG_N = 1 << REG_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_tgt,
    input  logic [HOST_AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [BYTE_W-1:0]      reg_data,
    input  logic                   dirty_clr,
    input  logic [PAT_AW-1:0]      pat_raddr,
    input  logic [SMALL_AW-1:0]    col_raddr,
    input  logic [SMALL_AW-1:0]    scr_raddr,
    input  logic [REG_AW-1:0]      reg_raddr,
    output logic [BYTE_W-1:0]      pat_rdata,
    output logic [BYTE_W-1:0]      col_rdata,
    output logic [BYTE_W-1:0]      scr_rdata,
    output logic [BYTE_W-1:0]      reg_rdata,
    output logic [PAGES-1:0]       pat_dirty,
    output logic [SMALL_DEPTH-1:0] col_dirty,
    output logic [REG_N-1:0]       reg_dirty,
    output logic [N_STORES-1:0]    chg_summary
);
    localparam int PAGE_W = PAT_AW - PAGE_LSB;

    byte_wr_t bw;
    reg_wr_t  rw;

    assign bw = '{en: wr_en, tgt: tgt_e'(wr_tgt), addr: wr_addr, data: wr_data};
    assign rw = '{en: reg_we, idx: reg_addr, data: reg_data};

    logic pat_chg, col_chg, scr_chg, reg_chg;

    logic [PAT_AW-1:0]   pat_waddr;
    logic [SMALL_AW-1:0] small_waddr;
    logic [PAGE_W-1:0]   page_idx;

    assign pat_waddr   = bw.addr[PAT_AW-1:0];
    assign small_waddr = bw.addr[SMALL_AW-1:0];
    assign page_idx    = pat_waddr[PAT_AW-1:PAGE_LSB];

    tracked_ram #(.AW(PAT_AW)) u_pat (
        .clk(clk), .rst(rst),
        .we(hits(bw, TGT_PAT)), .waddr(pat_waddr), .wdata(bw.data),
        .raddr(pat_raddr), .rdata(pat_rdata), .changed(pat_chg)
    );

    tracked_ram #(.AW(SMALL_AW)) u_col (
        .clk(clk), .rst(rst),
        .we(hits(bw, TGT_COL)), .waddr(small_waddr), .wdata(bw.data),
        .raddr(col_raddr), .rdata(col_rdata), .changed(col_chg)
    );

    tracked_ram #(.AW(SMALL_AW)) u_scr (
        .clk(clk), .rst(rst),
        .we(hits(bw, TGT_SCR)), .waddr(small_waddr), .wdata(bw.data),
        .raddr(scr_raddr), .rdata(scr_rdata), .changed(scr_chg)
    );

    tracked_ram #(.AW(REG_AW)) u_reg (
        .clk(clk), .rst(rst),
        .we(rw.en), .waddr(rw.idx), .wdata(rw.data),
        .raddr(reg_raddr), .rdata(reg_rdata), .changed(reg_chg)
    );

    logic [PAGES-1:0]       pat_mask;
    logic [SMALL_DEPTH-1:0] col_mask;
    logic [REG_N-1:0]       reg_mask;
    logic [N_STORES-1:0]    sum_mask;

    always_comb begin
        pat_mask = '0;
        col_mask = '0;
        reg_mask = '0;
        pat_mask[page_idx]    = pat_chg;
        col_mask[small_waddr] = col_chg;
        reg_mask[rw.idx]      = reg_chg;
        sum_mask = '0;
        sum_mask[SUM_PAT] = pat_chg;
        sum_mask[SUM_COL] = col_chg;
        sum_mask[SUM_SCR] = scr_chg;
        sum_mask[SUM_REG] = reg_chg;
    end

    dirty_map #(.BITS(PAGES)) u_pat_map (
        .clk(clk), .rst(rst), .clr(dirty_clr), .set_mask(pat_mask), .map(pat_dirty)
    );

    dirty_map #(.BITS(SMALL_DEPTH)) u_col_map (
        .clk(clk), .rst(rst), .clr(dirty_clr), .set_mask(col_mask), .map(col_dirty)
    );

    dirty_map #(.BITS(REG_N)) u_reg_map (
        .clk(clk), .rst(rst), .clr(dirty_clr), .set_mask(reg_mask), .map(reg_dirty)
    );

    dirty_map #(.BITS(N_STORES)) u_sum_map (
        .clk(clk), .rst(rst), .clr(dirty_clr), .set_mask(sum_mask), .map(chg_summary)
    );

endmodule

// File: rtl/tile_mem_tracker_chk.sv
module tile_mem_tracker_chk
    import tile_mem_pkg::*;
#(
    parameter int PAT_AW = 12,
    localparam int PAGES = 1 << (PAT_AW - PAGE_LSB)
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          wr_tgt,
    input logic [HOST_AW-1:0]  wr_addr,
    input logic [REG_AW-1:0]   reg_addr,
    input logic                dirty_clr,
    input logic                pat_chg,
    input logic                col_chg,
    input logic                scr_chg,
    input logic                reg_chg,
    input logic [PAGES-1:0]    pat_dirty,
    input logic [127:0]        col_dirty,
    input logic [31:0]         reg_dirty,
    input logic [3:0]          chg_summary
);
    logic any_chg;
    assign any_chg = pat_chg || col_chg || scr_chg || reg_chg;

    // R1
    a_r1_none_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tgt == 2'd3) |-> (!pat_chg && !col_chg && !scr_chg));

    // R2
    a_r2_quiet_stable: assert property (@(posedge clk) disable iff (rst)
        (!dirty_clr && !any_chg) |=> ($stable(chg_summary) && $stable(pat_dirty)
                                      && $stable(col_dirty) && $stable(reg_dirty)));

    // R3
    a_r3_page_mark: assert property (@(posedge clk) disable iff (rst)
        pat_chg |=> pat_dirty[$past(wr_addr[PAT_AW-1:PAGE_LSB])]);

    // R4
    a_r4_col_mark: assert property (@(posedge clk) disable iff (rst)
        col_chg |=> col_dirty[$past(wr_addr[6:0])]);

    // R5
    a_r5_reg_mark: assert property (@(posedge clk) disable iff (rst)
        reg_chg |=> reg_dirty[$past(reg_addr)]);

    // R6
    a_r6_scr_summary: assert property (@(posedge clk) disable iff (rst)
        scr_chg |=> chg_summary[2]);

    a_r6_reg_summary: assert property (@(posedge clk) disable iff (rst)
        reg_chg |=> chg_summary[3]);

    // R8
    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        (dirty_clr && !any_chg) |=> (chg_summary == '0 && pat_dirty == '0
                                     && col_dirty == '0 && reg_dirty == '0));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        (dirty_clr && col_chg) |=> (chg_summary[1] && $countones(col_dirty) == 1));

endmodule

bind tile_mem_tracker tile_mem_tracker_chk #(.PAT_AW(PAT_AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .reg_addr(reg_addr), .dirty_clr(dirty_clr),
    .pat_chg(pat_chg), .col_chg(col_chg), .scr_chg(scr_chg), .reg_chg(reg_chg),
    .pat_dirty(pat_dirty), .col_dirty(col_dirty), .reg_dirty(reg_dirty),
    .chg_summary(chg_summary)
);

// File: tb/tile_mem_tracker_test.sv
module tile_mem_tracker_test;

    localparam int PAT_AW = 12;
    localparam int PAGES  = 1 << (PAT_AW - 8);
    localparam int NVEC   = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_tgt;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [7:0]  reg_data;
    logic        dirty_clr;
    logic [PAT_AW-1:0] pat_raddr;
    logic [6:0]  col_raddr, scr_raddr;
    logic [4:0]  reg_raddr;
    logic [7:0]  pat_rdata, col_rdata, scr_rdata, reg_rdata;
    logic [PAGES-1:0] pat_dirty;
    logic [127:0] col_dirty;
    logic [31:0] reg_dirty;
    logic [3:0]  chg_summary;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tile_mem_tracker #(.PAT_AW(PAT_AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
        .dirty_clr(dirty_clr), .pat_raddr(pat_raddr), .col_raddr(col_raddr),
        .scr_raddr(scr_raddr), .reg_raddr(reg_raddr), .pat_rdata(pat_rdata),
        .col_rdata(col_rdata), .scr_rdata(scr_rdata), .reg_rdata(reg_rdata),
        .pat_dirty(pat_dirty), .col_dirty(col_dirty), .reg_dirty(reg_dirty),
        .chg_summary(chg_summary)
    );

    // fields: tgt[34:33] addr[32:17] data[16:9] changed[8] readback[7:0]
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 16'h0123, 8'h00, 1'b0, 8'h00},  // equal to reset contents
        {2'd0, 16'h0123, 8'h5A, 1'b1, 8'h5A},  // page 1 changes
        {2'd0, 16'h0123, 8'h5A, 1'b0, 8'h5A},  // repeat
        {2'd1, 16'h0085, 8'h3C, 1'b1, 8'h3C},  // aliases to byte 5
        {2'd1, 16'h0005, 8'h3C, 1'b0, 8'h3C},  // repeat through alias
        {2'd2, 16'h007F, 8'h11, 1'b1, 8'h11},
        {2'd2, 16'h007F, 8'h11, 1'b0, 8'h11},
        {2'd0, 16'h0FFF, 8'hFF, 1'b1, 8'hFF},  // top page
        {2'd1, 16'h007F, 8'h01, 1'b1, 8'h01},  // top colour byte
        {2'd3, 16'h0005, 8'h99, 1'b0, 8'h3C}   // no target: colour 5 keeps 3C
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        dirty_clr = 1'b1;
        @(negedge clk);
        dirty_clr = 1'b0;
    endtask

    task automatic bwrite(input logic [1:0] t, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tgt = t; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_data = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] t, input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        pat_raddr = a[PAT_AW-1:0]; col_raddr = a[6:0]; scr_raddr = a[6:0]; reg_raddr = a[4:0];
        @(negedge clk);
        case (t)
            2'd0:    d = pat_rdata;
            2'd2:    d = scr_rdata;
            2'd3:    d = reg_rdata;
            default: d = col_rdata;
        endcase
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; wr_en = 0; wr_tgt = 0; wr_addr = 0; wr_data = 0;
        reg_we = 0; reg_addr = 0; reg_data = 0; dirty_clr = 0;
        pat_raddr = 0; col_raddr = 0; scr_raddr = 0; reg_raddr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 reset state
        check("R7 summary", 128'(chg_summary), 128'hF);
        check("R7 pat_dirty", 128'(pat_dirty), 128'({PAGES{1'b1}}));
        check("R7 col_dirty", col_dirty, {128{1'b1}});
        check("R7 reg_dirty", 128'(reg_dirty), 128'hFFFF_FFFF);
        rd(2'd0, 16'h0FFF, d); check("R7 pat read", 128'(d), 0);
        rd(2'd1, 16'h0040, d); check("R7 col read", 128'(d), 0);
        rd(2'd3, 16'h001F, d); check("R7 reg read", 128'(d), 0);

        // R8 clear
        clear_pulse();
        check("R8 clear summary", 128'(chg_summary), 0);
        check("R8 clear col", col_dirty, 0);

        // vector table: R1 R2 R3 R4 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  t;
            logic [15:0] a;
            logic [7:0]  dv, rb;
            logic        c;
            logic [127:0] exp_fine;
            {t, a, dv, c, rb} = VEC[i];
            clear_pulse();
            bwrite(t, a, dv);
            check("R6 summary", 128'(chg_summary), (c && t != 2'd3) ? (128'(1) << t) : 0);
            exp_fine = 0;
            if (c && t == 2'd0) exp_fine = 128'(1) << a[PAT_AW-1:8];
            check("R3 page marks", 128'(pat_dirty), (t == 2'd0) ? exp_fine : 0);
            exp_fine = 0;
            if (c && t == 2'd1) exp_fine = 128'(1) << a[6:0];
            check("R4 colour marks", col_dirty, exp_fine);
            rd((t == 2'd3) ? 2'd1 : t, a, d);
            check("R1 R2 R9 readback", 128'(d), 128'(rb));
        end

        // R5 register file
        clear_pulse();
        rwrite(5'd7, 8'h42);
        check("R5 reg mark", 128'(reg_dirty), 128'(32'h80));
        check("R5 summary bit 3", 128'(chg_summary), 128'h8);
        clear_pulse();
        rwrite(5'd7, 8'h42);
        check("R2 reg same data", 128'(reg_dirty), 0);
        rd(2'd3, 16'h0007, d); check("R5 reg readback", 128'(d), 128'h42);

        // R8 write in the clear cycle wins
        bwrite(2'd1, 16'h0009, 8'h77);
        @(negedge clk);
        dirty_clr = 1'b1; wr_en = 1'b1; wr_tgt = 2'd1; wr_addr = 16'h0009; wr_data = 8'h78;
        reg_we = 1'b1; reg_addr = 5'd31; reg_data = 8'h01;
        col_raddr = 7'd9;
        @(negedge clk);
        dirty_clr = 1'b0; wr_en = 1'b0; reg_we = 1'b0;
        check("R8 write wins col", col_dirty, 128'(1) << 9);
        check("R8 write wins reg", 128'(reg_dirty), 128'(32'h8000_0000));
        check("R8 write wins summary", 128'(chg_summary), 128'hA);
        // R9 read in the write cycle saw the old byte, next read the new one
        check("R9 read before write", 128'(col_rdata), 128'h77);
        @(negedge clk);
        check("R9 new byte next cycle", 128'(col_rdata), 128'h78);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule